// File: doc/BRIEF.md
# Multi-Input Edge Wakeup Controller

This block watches an 8-bit general-purpose input port and raises a wakeup request to a halted processor core when a chosen edge appears on any selected pin. Software picks the source pins through a per-bit enable register. It picks rising or falling per pin through a per-bit polarity register. It observes and clears captured events through a per-bit pending register. All three registers sit on a simple register bus with address, write strobe, write data and combinational read data.

Each pin goes through a two-flop synchronizer. The synchronized level is XORed with the pin's polarity bit, and an edge is a 0-to-1 step of that adjusted level from one clock to the next. A detected edge sets its pending bit whether or not the pin is enabled. The wakeup request is a level: it is high while any pending bit is set together with its enable bit. The enable and polarity registers clear on reset. The pending register has no reset, so software clears it before it relies on it.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset the enable register (address 0) and the polarity register (address 1) read 0x00, and the wakeup request is low.
- R2: The enable, polarity and pending registers at addresses 0, 1 and 2 read back the value last written when no edge intervenes. Address 3 reads 0x00.
- R3: A pin change driven between clock edges sets its pending bit at the third rising clock edge after the change and not at the second.
- R4: A polarity bit of 0 makes a pin trigger on a low-to-high change, and a value of 1 makes it trigger on a high-to-low change. The opposite change does not set pending.
- R5: A detected edge sets its pending bit even when the pin's enable bit is 0. In that case the wakeup request stays low.
- R6: The wakeup request is high exactly when some bit is set in both the pending and enable registers. Any single pin or any combination of pins can serve as a source.
- R7: Writing a 0 to a pending bit clears it, and writing a 1 sets it.
- R8: When a write of 0 to a pending bit and a detected edge on that bit fall in the same clock cycle, the bit ends up set.
- R9: Changing a polarity bit while the pin level stays put can set that pin's pending bit (pin low, polarity 0 to 1). If the enable bit was cleared first, the wakeup request stays low. After the pending bit is cleared and the pin is re-enabled, the request remains low.
- R10: The wakeup request does not depend on the halt flag. Once raised, it stays high until software clears the pending bit or the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address (0 enable, 1 polarity, 2 pending) |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i |
| pins_i | input | 8 | Asynchronous port pins |
| halt_i | input | 1 | Core is halted |
| wake_o | output | 1 | Wakeup request level |

## Verification
The bench builds the block with its defaults: 8 pins, a 2-bit address and two synchronizer stages. With two stages the edge-to-pending latency is exactly three clocks, so the bench can pin down the exact capture cycle. It can also aim a pending-clear write at the cycle in which a detected edge is being latched. With eight pins, a vector table can mix rising and falling polarities within one byte. It can check that only the matching half of the pins captures, and that the request follows only the enabled subset.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int PORT_W   = 8;
    localparam int NUM_REGS = 3;
    localparam int ADDR_W   = $clog2(NUM_REGS + 1);
    localparam int SYNC_N   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE  = 2'd0,
        REG_POLAR   = 2'd1,
        REG_PENDING = 2'd2,
        REG_NONE    = 2'd3
    } wk_reg_e;

    function automatic wk_reg_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            2'd0:    return REG_ENABLE;
            2'd1:    return REG_POLAR;
            2'd2:    return REG_PENDING;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    chain_q[s] <= '0;
                else if (s == 0)
                    chain_q[s] <= async_i;
                else
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] polar_i,
    output logic [W-1:0] hit_o
);
    // Polarity-adjusted level: falling-edge pins are inverted so that a
    // detected event is always a 0 -> 1 step of the adjusted level.
    logic [W-1:0] adj;
    logic [W-1:0] adj_q;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            assign adj[b] = level_i[b] ^ polar_i[b];

            always_ff @(posedge clk_i) begin
                if (rst_i)
                    adj_q[b] <= 1'b0;
                else
                    adj_q[b] <= adj[b];
            end

            assign hit_o[b] = adj[b] & ~adj_q[b];
        end
    endgenerate
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [W-1:0]  hit_i,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  polar_o,
    output logic [W-1:0]  pend_o,
    output logic [W-1:0]  rd_data_o
);
    wk_reg_e sel;
    logic [W-1:0] en_q, polar_q, pend_q;

    assign sel = decode_addr(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q    <= '0;
            polar_q <= '0;
        end else if (wr_en_i) begin
            if (sel == REG_ENABLE) en_q    <= wr_data_i;
            if (sel == REG_POLAR)  polar_q <= wr_data_i;
        end
    end

    // No reset on purpose: contents are undefined until software writes them.
    // A captured edge takes precedence over a simultaneous software write.
    always_ff @(posedge clk_i) begin
        if (wr_en_i && sel == REG_PENDING)
            pend_q <= wr_data_i | hit_i;
        else
            pend_q <= pend_q | hit_i;
    end

    always_comb begin
        case (sel)
            REG_ENABLE:  rd_data_o = en_q;
            REG_POLAR:   rd_data_o = polar_q;
            REG_PENDING: rd_data_o = pend_q;
            default:     rd_data_o = '0;
        endcase
    end

    assign en_o    = en_q;
    assign polar_o = polar_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl #(
    parameter int WIDTH  = wkup_pkg::PORT_W,
    parameter int ADDR_W = wkup_pkg::ADDR_W,
    parameter int SYNC_N = wkup_pkg::SYNC_N
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    output logic [WIDTH-1:0]  rd_data_o,
    input  logic [WIDTH-1:0]  pins_i,
    input  logic              halt_i,
    output logic              wake_o
);
    logic [WIDTH-1:0] pins_sync, hit, en_q, polar_q, pend_q;

    wkup_sync #(.W(WIDTH), .STAGES(SYNC_N)) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (pins_i),
        .sync_o  (pins_sync)
    );

    wkup_edge #(.W(WIDTH)) edge_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (pins_sync),
        .polar_i (polar_q),
        .hit_o   (hit)
    );

    wkup_regs #(.W(WIDTH), .AW(ADDR_W)) regs_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .hit_i     (hit),
        .en_o      (en_q),
        .polar_o   (polar_q),
        .pend_o    (pend_q),
        .rd_data_o (rd_data_o)
    );

    // halt_i is informational: the request is a level regardless of halt.
    assign wake_o = |(pend_q & en_q);
endmodule

// File: rtl/wkup_ctrl_chk.sv
module wkup_ctrl_chk #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [AW-1:0] addr_i,
    input logic          wr_en_i,
    input logic [W-1:0]  wr_data_i,
    input logic          halt_i,
    input logic          wake_o,
    input logic [W-1:0]  en_q,
    input logic [W-1:0]  polar_q,
    input logic [W-1:0]  pend_q,
    input logic [W-1:0]  hit
);
    logic pend_wr, en_wr;
    assign pend_wr = wr_en_i && addr_i == 2;
    assign en_wr   = wr_en_i && addr_i == 0;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (en_q == '0 && polar_q == '0));

    // R5
    edge_sets_pend_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

    // R7
    pend_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_wr && hit == '0) |=> (pend_q == $past(wr_data_i)));

    // R2
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pend_wr && hit == '0) |=> $stable(pend_q));

    // R6
    enabled_hit_wakes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|(hit & en_q)) && !en_wr) |=> wake_o);

    // R10
    halt_wake_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (halt_i && wake_o && !wr_en_i) |=> wake_o);
endmodule

bind wkup_ctrl wkup_ctrl_chk #(.W(WIDTH), .AW(ADDR_W)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .halt_i    (halt_i),
    .wake_o    (wake_o),
    .en_q      (en_q),
    .polar_q   (polar_q),
    .pend_q    (pend_q),
    .hit       (hit)
);

// File: tb/wkup_ctrl_tb.sv
`timescale 1ns/1ps
module wkup_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pins = '0;
    logic       halt = 1'b0;
    logic       wake;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wkup_ctrl dut_i (
        .clk_i (clk), .rst_i (rst), .addr_i (addr), .wr_en_i (we),
        .wr_data_i (wdata), .rd_data_o (rdata), .pins_i (pins),
        .halt_i (halt), .wake_o (wake)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] pol;
        logic [7:0] pre;
        logic [7:0] post;
        logic [7:0] pend;
        logic       wk;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1},
        '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0},
        '{8'h0F, 8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b1},
        '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0},
        '{8'h01, 8'hF0, 8'hF0, 8'h0F, 8'hFF, 1'b1},
        '{8'h80, 8'hAA, 8'h55, 8'hAA, 8'h00, 1'b0},
        '{8'h10, 8'h00, 8'h00, 8'h10, 8'h10, 1'b1},
        '{8'h02, 8'h0C, 8'h0C, 8'h01, 8'h0D, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, d); chk("R1 enable", d, 8'h00);
        rd(2'd1, d); chk("R1 polarity", d, 8'h00);
        chk("R1 wake", {7'b0, wake}, 8'h00);

        // R2: read/write and unmapped address
        wr(2'd1, 8'h5A); rd(2'd1, d); chk("R2 polarity rw", d, 8'h5A);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00); rd(2'd2, d); chk("R2 pending rw", d, 8'h00);
        wr(2'd0, 8'hC3); rd(2'd0, d); chk("R2 enable rw", d, 8'hC3);
        rd(2'd3, d); chk("R2 unmapped", d, 8'h00);
        wr(2'd0, 8'h00);

        // R4, R5, R6: vector table
        foreach (VEC[i]) begin
            wr(2'd0, 8'h00);
            wr(2'd1, VEC[i].pol);
            @(negedge clk); pins = VEC[i].pre;
            cycles(5);
            wr(2'd2, 8'h00);
            wr(2'd0, VEC[i].en);
            @(negedge clk); pins = VEC[i].post;
            cycles(3);
            rd(2'd2, d); chk($sformatf("R4 R5 vec%0d pending", i), d, VEC[i].pend);
            chk($sformatf("R6 vec%0d wake", i), {7'b0, wake}, {7'b0, VEC[i].wk});
        end

        // R3: latency of capture
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        @(negedge clk); pins = 8'h00;
        cycles(5);
        wr(2'd2, 8'h00);
        pins = 8'h04;
        cycles(2);
        addr = 2'd2; #0.5; chk("R3 not yet", rdata, 8'h00);
        cycles(1);
        addr = 2'd2; #0.5; chk("R3 captured", rdata, 8'h04);

        // R7: write 1 sets, write 0 clears
        wr(2'd2, 8'h81); rd(2'd2, d); chk("R7 set", d, 8'h81);
        wr(2'd0, 8'h01); chk("R7 wake on set", {7'b0, wake}, 8'h01);
        wr(2'd2, 8'h00); rd(2'd2, d); chk("R7 clear", d, 8'h00);
        chk("R7 wake after clear", {7'b0, wake}, 8'h00);

        // R8: edge beats same-cycle clear
        wr(2'd0, 8'h00);
        pins = 8'h00;
        cycles(5);
        wr(2'd2, 8'h00);
        pins = 8'h20;
        repeat (2) @(posedge clk);
        @(negedge clk);
        addr = 2'd2; wdata = 8'h00; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        rd(2'd2, d); chk("R8 edge wins", d, 8'h20);

        // R9: polarity change hazard with enable cleared first
        pins = 8'h00;
        cycles(5);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h01);
        cycles(1);
        rd(2'd2, d); chk("R9 spurious pending", d, 8'h01);
        chk("R9 wake held low", {7'b0, wake}, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd2, d); chk("R9 pending cleared", d, 8'h00);
        chk("R9 wake after re-enable", {7'b0, wake}, 8'h00);

        // R10: level independent of halt
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        halt = 1'b0;
        pins = 8'h01;
        cycles(4);
        chk("R10 wake while running", {7'b0, wake}, 8'h01);
        halt = 1'b1;
        cycles(6);
        chk("R10 wake held in halt", {7'b0, wake}, 8'h01);
        halt = 1'b0;
        cycles(2);
        chk("R10 wake held after halt", {7'b0, wake}, 8'h01);
        wr(2'd2, 8'h00);
        chk("R10 wake drops on clear", {7'b0, wake}, 8'h00);

        summary();
    end
endmodule